// File: doc/BRIEF.md
# Monotonic Multi-Stream Wall Clock Gate

This block owns a 64-bit wall clock register that may only advance in step with a set of audio streams. A caller presents an update request carrying a candidate time, a force flag, and, for every stream, an active bit, a "has passed the candidate" bit and that stream's absolute elapsed wall clock. Without force, the register moves only when every active stream has already passed the candidate. It then jumps to the largest of the candidate and the active streams' elapsed positions, so no stream is left behind the published clock. With force, the candidate is written as given.

The block also watches how healthy the updates are. A non-forced update whose computed target lies below the current register is refused and reported as a backward error. A non-forced update that lands exactly on the current value is stale. A saturating counter tracks consecutive stale updates, and an error is reported once the run of stale updates grows too long. Each request receives a one-cycle response that says whether the register now equals the update's target.

Top module: `wclk_gate`

## Requirements
- R1: After synchronous reset the wall clock reads 0, the stale count reads 0, and rsp_valid, rsp_match, rsp_backward and rsp_stale_err are all 0.
- R2: With upd_force low and at least one stream that has strm_active=1 and strm_passed=0, the wall clock keeps its value. rsp_match is then 1 only if the wall clock already equals upd_cand.
- R3: With upd_force low and every active stream passed, the target is the maximum of upd_cand and the elapsed values of the active streams. The wall clock takes that target unless R6 applies. Stream i's elapsed value sits in bits [64*i+63 : 64*i] of strm_elapsed.
- R4: A stream with strm_active=0 counts as passed, and its elapsed value takes no part in the maximum. With no active stream, a non-forced update targets upd_cand.
- R5: With upd_force high, the wall clock takes upd_cand regardless of the stream flags and positions, even when upd_cand is lower than the current value. rsp_match is 1.
- R6: A non-forced update whose target is below the current wall clock leaves the register unchanged, raises rsp_backward with the response, and reports rsp_match=0.
- R7: A non-forced update whose target equals the current wall clock increments the stale count, which saturates at 2^CNT_W-1. A non-forced update that advances the clock clears the count. Forced, blocked and backward updates leave the count unchanged.
- R8: rsp_stale_err is 1 in the response of a stale update exactly when the count after that update exceeds STALE_LIMIT (default 3). With the defaults this is the fourth and every later stale update in a row.
- R9: rsp_valid is high in exactly the cycle after each cycle with upd_valid high. In that same cycle the wall clock, stale_cnt and the other response outputs show the result of the update. Without upd_valid the wall clock does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update request strobe |
| upd_force | input | 1 | Write the candidate unconditionally |
| upd_cand | input | 64 | Candidate wall clock value |
| strm_active | input | NUM_STRM | Per-stream participation mask |
| strm_passed | input | NUM_STRM | Per-stream "has passed candidate" flag |
| strm_elapsed | input | 64*NUM_STRM | Per-stream absolute elapsed wall clock, stream 0 in the low bits |
| wall_clk | output | 64 | Current wall clock register |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_match | output | 1 | Register equals the update's target |
| rsp_backward | output | 1 | Non-forced target was below the register and was refused |
| rsp_stale_err | output | 1 | Stale run has exceeded the limit |
| stale_cnt | output | CNT_W | Consecutive stale update count |

## Verification
The hardest state to reach is a long run of stale updates. Each stale update needs a non-forced request whose maximum over the candidate and the active stream positions lands exactly on the current register, with every active stream flagged as passed. The stimulus first forces the clock to a known value. It then repeats requests whose candidate equals that value and whose stream positions all lie below it, so the counter climbs through the error threshold and into saturation. A later advance then shows the count being cleared. A backward request is placed among these to confirm that a refused update leaves the count alone, and a forced write in the middle of a run shows that forcing does not disturb the count.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

    localparam int WCLK_W = 64;

    typedef logic [WCLK_W-1:0] wclk_t;

    typedef struct packed {
        logic  force_upd;
        wclk_t cand;
    } upd_req_t;

    typedef struct packed {
        logic  write_en;
        logic  backward;
        logic  stale;
        logic  advance;
        wclk_t target;
    } upd_dec_t;

    function automatic wclk_t wclk_max(input wclk_t a, input wclk_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wclk_strm_eval.sv
module wclk_strm_eval
    import wclk_pkg::*;
#(
    parameter int NUM_STRM = 3
) (
    input  logic                       [NUM_STRM-1:0] active,
    input  logic                       [NUM_STRM-1:0] passed,
    input  logic [NUM_STRM*WCLK_W-1:0]                elapsed,
    input  wclk_t                                     cand,
    output logic                                      all_passed,
    output wclk_t                                     peak
);

    wclk_t chain [NUM_STRM+1];

    assign chain[0] = cand;

    for (genvar i = 0; i < NUM_STRM; i++) begin : g_strm
        wclk_t pos_i;
        assign pos_i       = elapsed[i*WCLK_W +: WCLK_W];
        assign chain[i+1]  = active[i] ? wclk_max(chain[i], pos_i) : chain[i];
    end

    assign all_passed = &(passed | ~active);
    assign peak       = chain[NUM_STRM];

endmodule

// File: rtl/wclk_decide.sv
module wclk_decide
    import wclk_pkg::*;
(
    input  upd_req_t req,
    input  logic     all_passed,
    input  wclk_t    peak,
    input  wclk_t    cur,
    output upd_dec_t dec
);

    logic gated;

    always_comb begin
        gated        = !req.force_upd && all_passed;
        dec.backward = gated && (peak <  cur);
        dec.stale    = gated && (peak == cur);
        dec.advance  = gated && (peak >  cur);
        dec.write_en = req.force_upd || dec.stale || dec.advance;
        if (req.force_upd)
            dec.target = req.cand;
        else if (all_passed)
            dec.target = peak;
        else
            dec.target = req.cand;
    end

endmodule

// File: rtl/wclk_stale_trk.sv
module wclk_stale_trk #(
    parameter int CNT_W       = 3,
    parameter int STALE_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic             stale,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt,
    output logic             err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (upd_en) begin
            if (stale)
                cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
            else if (advance)
                cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            err <= upd_en && stale && (int'(cnt_nxt) > STALE_LIMIT);
        end
    end

endmodule

// File: rtl/wclk_gate.sv
module wclk_gate
    import wclk_pkg::*;
#(
    parameter int NUM_STRM    = 3,
    parameter int CNT_W       = 3,
    parameter int STALE_LIMIT = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_valid,
    input  logic                       upd_force,
    input  logic [63:0]                upd_cand,
    input  logic [NUM_STRM-1:0]        strm_active,
    input  logic [NUM_STRM-1:0]        strm_passed,
    input  logic [NUM_STRM*64-1:0]     strm_elapsed,
    output logic [63:0]                wall_clk,
    output logic                       rsp_valid,
    output logic                       rsp_match,
    output logic                       rsp_backward,
    output logic                       rsp_stale_err,
    output logic [CNT_W-1:0]           stale_cnt
);

    upd_req_t req;
    upd_dec_t dec;
    logic     all_passed;
    wclk_t    peak;
    wclk_t    wall_nxt;

    assign req.force_upd = upd_force;
    assign req.cand      = upd_cand;

    wclk_strm_eval #(.NUM_STRM(NUM_STRM)) u_eval (
        .active     (strm_active),
        .passed     (strm_passed),
        .elapsed    (strm_elapsed),
        .cand       (upd_cand),
        .all_passed (all_passed),
        .peak       (peak)
    );

    wclk_decide u_dec (
        .req        (req),
        .all_passed (all_passed),
        .peak       (peak),
        .cur        (wall_clk),
        .dec        (dec)
    );

    wclk_stale_trk #(.CNT_W(CNT_W), .STALE_LIMIT(STALE_LIMIT)) u_stale (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (upd_valid),
        .stale   (dec.stale),
        .advance (dec.advance),
        .cnt     (stale_cnt),
        .err     (rsp_stale_err)
    );

    assign wall_nxt = (upd_valid && dec.write_en) ? dec.target : wall_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            wall_clk     <= '0;
            rsp_valid    <= 1'b0;
            rsp_match    <= 1'b0;
            rsp_backward <= 1'b0;
        end else begin
            wall_clk     <= wall_nxt;
            rsp_valid    <= upd_valid;
            rsp_match    <= upd_valid && (wall_nxt == dec.target);
            rsp_backward <= upd_valid && dec.backward;
        end
    end

endmodule

// File: rtl/wclk_gate_chk.sv
module wclk_gate_chk #(
    parameter int NUM_STRM    = 3,
    parameter int CNT_W       = 3,
    parameter int STALE_LIMIT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             upd_force,
    input logic [63:0]      wall_clk,
    input logic             rsp_valid,
    input logic             rsp_match,
    input logic             rsp_backward,
    input logic             rsp_stale_err,
    input logic [CNT_W-1:0] stale_cnt
);

    p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> rsp_valid);

    p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> !rsp_valid);

    p_idle_holds_clock_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(wall_clk));

    p_unforced_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_force) |=> (wall_clk >= $past(wall_clk)));

    p_backward_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_force) |=> (rsp_backward -> (!rsp_match && wall_clk == $past(wall_clk))));

    p_stale_err_above_limit_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_stale_err |-> (int'(stale_cnt) > STALE_LIMIT));

    p_stale_err_needs_resp_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_stale_err |-> rsp_valid);

    p_count_steady_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(stale_cnt));

    p_forced_match_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_force) |=> (rsp_match && !rsp_backward && $stable(stale_cnt)));

endmodule

bind wclk_gate wclk_gate_chk #(
    .NUM_STRM    (NUM_STRM),
    .CNT_W       (CNT_W),
    .STALE_LIMIT (STALE_LIMIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .upd_valid     (upd_valid),
    .upd_force     (upd_force),
    .wall_clk      (wall_clk),
    .rsp_valid     (rsp_valid),
    .rsp_match     (rsp_match),
    .rsp_backward  (rsp_backward),
    .rsp_stale_err (rsp_stale_err),
    .stale_cnt     (stale_cnt)
);

// File: tb/wclk_gate_test.sv
module wclk_gate_test;

    localparam int NS = 3;
    localparam int CW = 3;

    typedef struct packed {
        logic        frc;
        logic [63:0] cand;
        logic [2:0]  act;
        logic [2:0]  pas;
        logic [63:0] p0;
        logic [63:0] p1;
        logic [63:0] p2;
        logic [63:0] e_wall;
        logic        e_match;
        logic        e_bk;
        logic [2:0]  e_cnt;
        logic        e_err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R2 blocked: stream 2 active but not passed
        '{1'b0, 64'd100, 3'b111, 3'b011, 64'd120, 64'd90, 64'd80, 64'd0, 1'b0, 1'b0, 3'd0, 1'b0},
        // R3 all passed: jump to max 120
        '{1'b0, 64'd100, 3'b111, 3'b111, 64'd120, 64'd90, 64'd80, 64'd120, 1'b1, 1'b0, 3'd0, 1'b0},
        // R2/R4 inactive stream 1 ignored, active stream 2 not passed
        '{1'b0, 64'd150, 3'b101, 3'b001, 64'd160, 64'd999, 64'd140, 64'd120, 1'b0, 1'b0, 3'd0, 1'b0},
        // R4 inactive stream 1 large position excluded from max
        '{1'b0, 64'd150, 3'b101, 3'b101, 64'd160, 64'd999, 64'd140, 64'd160, 1'b1, 1'b0, 3'd0, 1'b0},
        // R5 forced write downwards, flags ignored
        '{1'b1, 64'd50, 3'b111, 3'b000, 64'd500, 64'd500, 64'd500, 64'd50, 1'b1, 1'b0, 3'd0, 1'b0},
        // R6 backward target 45 below 50 refused
        '{1'b0, 64'd40, 3'b111, 3'b111, 64'd45, 64'd30, 64'd20, 64'd50, 1'b0, 1'b1, 3'd0, 1'b0},
        // R7 stale runs 1..5, R8 error from fourth
        '{1'b0, 64'd50, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd50, 1'b1, 1'b0, 3'd1, 1'b0},
        '{1'b0, 64'd50, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd50, 1'b1, 1'b0, 3'd2, 1'b0},
        '{1'b0, 64'd50, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd50, 1'b1, 1'b0, 3'd3, 1'b0},
        '{1'b0, 64'd50, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd50, 1'b1, 1'b0, 3'd4, 1'b1},
        '{1'b0, 64'd50, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd50, 1'b1, 1'b0, 3'd5, 1'b1},
        // R7 advance clears count
        '{1'b0, 64'd60, 3'b111, 3'b111, 64'd10, 64'd20, 64'd30, 64'd60, 1'b1, 1'b0, 3'd0, 1'b0},
        // R4 no active stream: candidate taken
        '{1'b0, 64'd70, 3'b000, 3'b000, 64'd900, 64'd900, 64'd900, 64'd70, 1'b1, 1'b0, 3'd0, 1'b0},
        // R2 blocked but register already equals candidate: match
        '{1'b0, 64'd70, 3'b001, 3'b000, 64'd80, 64'd0, 64'd0, 64'd70, 1'b1, 1'b0, 3'd0, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               upd_valid;
    logic               upd_force;
    logic [63:0]        upd_cand;
    logic [NS-1:0]      strm_active;
    logic [NS-1:0]      strm_passed;
    logic [NS*64-1:0]   strm_elapsed;
    logic [63:0]        wall_clk;
    logic               rsp_valid;
    logic               rsp_match;
    logic               rsp_backward;
    logic               rsp_stale_err;
    logic [CW-1:0]      stale_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wclk_gate #(.NUM_STRM(NS), .CNT_W(CW), .STALE_LIMIT(3)) uut (
        .clk           (clk),
        .rst           (rst),
        .upd_valid     (upd_valid),
        .upd_force     (upd_force),
        .upd_cand      (upd_cand),
        .strm_active   (strm_active),
        .strm_passed   (strm_passed),
        .strm_elapsed  (strm_elapsed),
        .wall_clk      (wall_clk),
        .rsp_valid     (rsp_valid),
        .rsp_match     (rsp_match),
        .rsp_backward  (rsp_backward),
        .rsp_stale_err (rsp_stale_err),
        .stale_cnt     (stale_cnt)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic request(input logic frc, input logic [63:0] cand, input logic [2:0] act,
                           input logic [2:0] pas, input logic [63:0] p0, input logic [63:0] p1,
                           input logic [63:0] p2);
        @(negedge clk);
        upd_valid    = 1'b1;
        upd_force    = frc;
        upd_cand     = cand;
        strm_active  = act;
        strm_passed  = pas;
        strm_elapsed = {p2, p1, p0};
        @(posedge clk);
        #5;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        upd_valid = 1'b0;
        @(posedge clk);
        #5;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst          = 1'b1;
        upd_valid    = 1'b0;
        upd_force    = 1'b0;
        upd_cand     = '0;
        strm_active  = '0;
        strm_passed  = '0;
        strm_elapsed = '0;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk(wall_clk == 0, "R1 wall_clk", wall_clk, 0);
        chk(stale_cnt == 0, "R1 stale_cnt", 64'(stale_cnt), 0);
        chk(!rsp_valid && !rsp_match && !rsp_backward && !rsp_stale_err, "R1 response flags",
            {rsp_valid, rsp_match, rsp_backward, rsp_stale_err}, 0);
        @(negedge clk);
        rst = 1'b0;
        idle_cycle();
        chk(!rsp_valid, "R9 no response when idle", 64'(rsp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            request(VECS[i].frc, VECS[i].cand, VECS[i].act, VECS[i].pas,
                    VECS[i].p0, VECS[i].p1, VECS[i].p2);
            chk(rsp_valid, $sformatf("R9 vec%0d rsp_valid", i), 64'(rsp_valid), 1);
            chk(wall_clk == VECS[i].e_wall, $sformatf("R3 vec%0d wall_clk", i), wall_clk, VECS[i].e_wall);
            chk(rsp_match == VECS[i].e_match, $sformatf("R9 vec%0d rsp_match", i), 64'(rsp_match), 64'(VECS[i].e_match));
            chk(rsp_backward == VECS[i].e_bk, $sformatf("R6 vec%0d rsp_backward", i), 64'(rsp_backward), 64'(VECS[i].e_bk));
            chk(stale_cnt == VECS[i].e_cnt, $sformatf("R7 vec%0d stale_cnt", i), 64'(stale_cnt), 64'(VECS[i].e_cnt));
            chk(rsp_stale_err == VECS[i].e_err, $sformatf("R8 vec%0d rsp_stale_err", i), 64'(rsp_stale_err), 64'(VECS[i].e_err));
        end

        idle_cycle();
        chk(!rsp_valid, "R9 response lasts one cycle", 64'(rsp_valid), 0);
        chk(wall_clk == 70, "R9 idle keeps clock", wall_clk, 70);

        // R7 saturation of the stale count at 7, R8 error persists
        for (int k = 1; k <= 9; k++) begin
            request(1'b0, 64'd70, 3'b111, 3'b111, 64'd1, 64'd2, 64'd3);
            chk(stale_cnt == ((k > 7) ? 7 : k), $sformatf("R7 saturate step %0d", k),
                64'(stale_cnt), (k > 7) ? 7 : k);
            chk(rsp_stale_err == (k > 3), $sformatf("R8 stale run step %0d", k),
                64'(rsp_stale_err), 64'(k > 3));
        end

        // R7 forced write keeps the count; backward keeps it too
        request(1'b1, 64'd200, 3'b000, 3'b000, 64'd0, 64'd0, 64'd0);
        chk(wall_clk == 200, "R5 forced upward write", wall_clk, 200);
        chk(stale_cnt == 7, "R7 forced leaves count", 64'(stale_cnt), 7);
        chk(!rsp_stale_err, "R8 no error on forced write", 64'(rsp_stale_err), 0);
        request(1'b0, 64'd100, 3'b010, 3'b010, 64'd0, 64'd150, 64'd0);
        chk(rsp_backward && wall_clk == 200, "R6 backward refused", wall_clk, 200);
        chk(stale_cnt == 7, "R7 backward leaves count", 64'(stale_cnt), 7);
        request(1'b0, 64'd300, 3'b011, 3'b010, 64'd0, 64'd350, 64'd0);
        chk(wall_clk == 200 && !rsp_match, "R2 blocked by stream 0", wall_clk, 200);
        chk(stale_cnt == 7, "R7 blocked leaves count", 64'(stale_cnt), 7);
        request(1'b0, 64'd300, 3'b011, 3'b011, 64'd310, 64'd350, 64'd0);
        chk(wall_clk == 350 && rsp_match, "R3 max picks stream 1", wall_clk, 350);
        chk(stale_cnt == 0, "R7 advance clears count", 64'(stale_cnt), 0);

        // R1 reset mid-run
        @(negedge clk);
        upd_valid = 1'b0;
        rst       = 1'b1;
        @(posedge clk);
        #5;
        chk(wall_clk == 0 && stale_cnt == 0, "R1 reset clears state", wall_clk, 0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule